// File: doc/BRIEF.md
# Character-Sync Serial Receiver with SYN Hunt

The block is the receive half of a character-oriented synchronous link. After reset, or after a hunt command, it is in hunt mode. In hunt mode it shifts every strobed bit into a history window and compares that window against one or two SYN frames. A SYN frame is the programmed SYN value cut to the character length, plus its parity bit when parity is on. Sync can also be forced from an external sync input. Once it has sync, it cuts the bit stream into frames of the programmed length and checks the parity of each frame. It then hands characters to the consumer, one per cycle-wide valid pulse.

On the way out, a filter can drop SYN characters. In transparent text it also removes DLE escapes. A doubled DLE yields one DLE, a DLE followed by a SYN vanishes entirely, and a DLE followed by any other character yields only that character. Bits arrive least significant first, each marked by a one-cycle bit strobe from an external clock-recovery stage.

Top module: `csync_rx`

## Requirements
- R1: While rst_ni is low, sync_o, data_valid_o and par_err_o are 0 and data_o is 0.
- R2: In hunt mode every strobed bit is compared. With two_syn_i low, sync_o rises in the cycle after the strobe of the bit that completes one SYN frame. The SYN frame is the low char-length bits of syn_char_i sent LSB first, followed by their parity bit when parity is enabled.
- R3: With two_syn_i high, sync_o rises only after two consecutive SYN frames. A single SYN frame followed by a non-SYN frame leaves it low.
- R4: With ext_sync_en_i high, a high ext_sync_i during hunt sets sync_o in the next cycle without a bit strobe. Framing then starts with the next strobed bit.
- R5: The character length is char_len_i, clamped to the range 5..8. Bits map LSB first onto data_o, and the unused upper bits are 0. After sync, data_valid_o pulses for one cycle in the cycle after the strobe of the last bit of a frame. That last bit is the parity bit when parity is enabled.
- R6: par_mode_i selects the parity: 0 none (no parity bit, par_err_o stays 0), 1 odd, 2 even, 3 forced. In forced mode the parity bit must equal par_force_i. par_err_o is high together with data_valid_o when the received parity bit is wrong.
- R7: With syn_strip_i high and transp_i low, characters equal to the SYN value are not delivered.
- R8: With transp_i high, a character equal to the DLE value is held back. Whatever follows it decides the output: DLE delivers one DLE, SYN delivers nothing, and any other character delivers only that character.
- R9: hunt_cmd_i clears sync_o and any pending valid in the next cycle. It discards a partial frame, the hunt history and a pending DLE, and takes priority over all other inputs.
- R10: rxd_i is ignored in any cycle where bit_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-cycle strobe marking a valid receive bit |
| rxd_i | input | 1 | Serial receive data |
| hunt_cmd_i | input | 1 | Return to hunt mode |
| ext_sync_en_i | input | 1 | Use the external sync input instead of the pattern |
| ext_sync_i | input | 1 | External sync indication |
| two_syn_i | input | 1 | Require two SYN frames for sync |
| syn_strip_i | input | 1 | Drop SYN characters from the output |
| transp_i | input | 1 | Transparent text: strip DLE escapes |
| char_len_i | input | 4 | Character length, clamped to 5..8 |
| par_mode_i | input | 2 | 0 none, 1 odd, 2 even, 3 forced |
| par_force_i | input | 1 | Expected parity bit in forced mode |
| syn_char_i | input | 8 | SYN character value |
| dle_char_i | input | 8 | DLE character value |
| sync_o | output | 1 | Character sync achieved |
| data_valid_o | output | 1 | One-cycle pulse with a delivered character |
| data_o | output | 8 | Delivered character, right aligned |
| par_err_o | output | 1 | Parity error for the delivered character |

## Verification
A hunt history that is misaligned or stale shows up as sync_o rising one strobe too early or too late. After that, every following character is shifted, so the first data_o value after sync is already wrong. A frame counter that slips by one bit corrupts the character delivered at the next frame boundary, and it also raises a false par_err_o whenever parity is on. A DLE-pending flag that is not cleared shows up on the first transparent character after the escape: that character goes missing, or a DLE appears that should not. The reference model is compared on every clock, so each of these faults is seen in the cycle it reaches a port.

// File: rtl/csync_pkg.sv
package csync_pkg;
  localparam int CHAR_W  = 8;
  localparam int MIN_LEN = 5;
  localparam int FRM_W   = CHAR_W + 1;
  localparam int LEN_W   = $clog2(FRM_W + 1);

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_ODD   = 2'd1,
    PAR_EVEN  = 2'd2,
    PAR_FORCE = 2'd3
  } par_mode_e;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    if (int'(l) < MIN_LEN) return LEN_W'(MIN_LEN);
    if (int'(l) > CHAR_W)  return LEN_W'(CHAR_W);
    return l;
  endfunction

  function automatic logic [CHAR_W-1:0] len_mask(input logic [LEN_W-1:0] l);
    logic [CHAR_W-1:0] m;
    for (int i = 0; i < CHAR_W; i++) m[i] = (i < int'(l));
    return m;
  endfunction

  // expected parity bit for an already masked character
  function automatic logic par_bit(input logic [CHAR_W-1:0] d, input par_mode_e m,
                                   input logic f);
    case (m)
      PAR_ODD:   return ~^d;
      PAR_EVEN:  return ^d;
      PAR_FORCE: return f;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/csync_hunt.sv
module csync_hunt
  import csync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [LEN_W-1:0]  len_i,
  input  par_mode_e         par_mode_i,
  input  logic              par_force_i,
  input  logic [CHAR_W-1:0] syn_i,
  input  logic              two_syn_i,
  output logic              match_o
);
  localparam int HW = 2 * FRM_W;
  localparam int FW = $clog2(HW + 1);

  logic [HW-1:0]    hist_q, hist_d, pat, win, msk;
  logic [FW-1:0]    fill_q, fill_d;
  logic [FRM_W-1:0] pat1;
  logic [CHAR_W-1:0] syn_m;
  int               w, need;

  always_comb begin
    hist_d = {bit_i, hist_q[HW-1:1]};
    fill_d = (int'(fill_q) < HW) ? fill_q + 1'b1 : fill_q;
    w      = int'(len_i) + ((par_mode_i != PAR_NONE) ? 1 : 0);
    need   = two_syn_i ? 2 * w : w;
    syn_m  = syn_i & len_mask(len_i);
    pat1   = FRM_W'(syn_m);
    if (par_mode_i != PAR_NONE) pat1[len_i] = par_bit(syn_m, par_mode_i, par_force_i);
    pat = HW'(pat1);
    if (two_syn_i) pat = pat | (HW'(pat1) << w);
    // newest bit sits at the top; align the last `need` bits to bit 0
    win     = hist_d >> (HW - need);
    msk     = (HW'(1) << need) - 1'b1;
    match_o = shift_i && (int'(fill_d) >= need) && ((win & msk) == pat);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clear_i) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (shift_i) begin
      hist_q <= hist_d;
      fill_q <= fill_d;
    end
  end

  // R2
  hunt_needs_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (int'(fill_q) + 1 >= int'(len_i)));
endmodule

// File: rtl/csync_framer.sv
module csync_framer
  import csync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic [LEN_W-1:0]  len_i,
  input  par_mode_e         par_mode_i,
  input  logic              par_force_i,
  output logic              done_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              perr_o
);
  logic [LEN_W-1:0] cnt_q, w;
  logic [FRM_W-1:0] frm_q, frm_d;
  logic             pbit;

  always_comb begin
    w     = len_i + LEN_W'(par_mode_i != PAR_NONE);
    frm_d = frm_q;
    frm_d[cnt_q] = bit_i;
    done_o = shift_i && (cnt_q == w - 1'b1);
    char_o = frm_d[CHAR_W-1:0] & len_mask(len_i);
    pbit   = frm_d[len_i];
    perr_o = (par_mode_i != PAR_NONE) && (pbit != par_bit(char_o, par_mode_i, par_force_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      frm_q <= '0;
    end else if (clear_i || done_o) begin
      cnt_q <= '0;
      frm_q <= '0;
    end else if (shift_i) begin
      cnt_q <= cnt_q + 1'b1;
      frm_q <= frm_d;
    end
  end

  // R5
  cnt_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < w);
endmodule

// File: rtl/csync_filter.sv
module csync_filter
  import csync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              in_valid_i,
  input  logic [CHAR_W-1:0] in_char_i,
  input  logic              in_perr_i,
  input  logic [CHAR_W-1:0] syn_i,
  input  logic [CHAR_W-1:0] dle_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              syn_strip_i,
  input  logic              transp_i,
  output logic              valid_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              perr_o
);
  logic              valid_q, perr_q, pend_q, pend_d, keep, is_syn, is_dle;
  logic [CHAR_W-1:0] data_q, msk;

  always_comb begin
    msk    = len_mask(len_i);
    is_syn = in_char_i == (syn_i & msk);
    is_dle = in_char_i == (dle_i & msk);
    pend_d = pend_q;
    keep   = 1'b0;
    if (in_valid_i) begin
      if (transp_i && pend_q) begin
        pend_d = 1'b0;
        keep   = !is_syn;
      end else if (transp_i && is_dle) begin
        pend_d = 1'b1;
      end else begin
        keep = !(syn_strip_i && is_syn);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      pend_q  <= 1'b0;
      data_q  <= '0;
    end else if (clear_i) begin
      valid_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      valid_q <= keep;
      pend_q  <= pend_d;
      if (keep) begin
        data_q <= in_char_i;
        perr_q <= in_perr_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign perr_o  = valid_q & perr_q;

  // R8
  dle_escape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && transp_i && !pend_q && is_dle && !clear_i) |=> !valid_o);
endmodule

// File: rtl/csync_rx.sv
module csync_rx
  import csync_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              rxd_i,
  input  logic              hunt_cmd_i,
  input  logic              ext_sync_en_i,
  input  logic              ext_sync_i,
  input  logic              two_syn_i,
  input  logic              syn_strip_i,
  input  logic              transp_i,
  input  logic [LEN_W-1:0]  char_len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              par_force_i,
  input  logic [CHAR_W-1:0] syn_char_i,
  input  logic [CHAR_W-1:0] dle_char_i,
  output logic              sync_o,
  output logic              data_valid_o,
  output logic [CHAR_W-1:0] data_o,
  output logic              par_err_o
);
  logic [LEN_W-1:0]  len;
  par_mode_e         pm;
  logic              sync_q, hunt_shift, frm_shift, ext_hit, match;
  logic              fr_done, fr_perr;
  logic [CHAR_W-1:0] fr_char;

  assign len        = clamp_len(char_len_i);
  assign pm         = par_mode_e'(par_mode_i);
  assign hunt_shift = bit_en_i & ~sync_q & ~hunt_cmd_i;
  assign frm_shift  = bit_en_i &  sync_q & ~hunt_cmd_i;
  assign ext_hit    = ext_sync_en_i & ext_sync_i & ~sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sync_q <= 1'b0;
    else if (hunt_cmd_i)        sync_q <= 1'b0;
    else if (ext_hit || match)  sync_q <= 1'b1;
  end
  assign sync_o = sync_q;

  csync_hunt u_hunt (
    .clk_i, .rst_ni, .clear_i(hunt_cmd_i), .shift_i(hunt_shift & ~ext_hit), .bit_i(rxd_i),
    .len_i(len), .par_mode_i(pm), .par_force_i, .syn_i(syn_char_i), .two_syn_i,
    .match_o(match)
  );

  csync_framer u_framer (
    .clk_i, .rst_ni, .clear_i(hunt_cmd_i), .shift_i(frm_shift), .bit_i(rxd_i),
    .len_i(len), .par_mode_i(pm), .par_force_i,
    .done_o(fr_done), .char_o(fr_char), .perr_o(fr_perr)
  );

  csync_filter u_filter (
    .clk_i, .rst_ni, .clear_i(hunt_cmd_i), .in_valid_i(fr_done), .in_char_i(fr_char),
    .in_perr_i(fr_perr), .syn_i(syn_char_i), .dle_i(dle_char_i), .len_i(len),
    .syn_strip_i, .transp_i, .valid_o(data_valid_o), .data_o, .perr_o(par_err_o)
  );

  // R9
  hunt_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_cmd_i |=> (!sync_o && !data_valid_o));
  // R2
  sync_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(bit_en_i || (ext_sync_en_i && ext_sync_i)));
  // R5
  valid_after_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(bit_en_i && sync_o && !hunt_cmd_i));
  // R6
  perr_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |-> data_valid_o);
  // R10
  no_strobe_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> !data_valid_o);
endmodule

// File: tb/sim_csync_rx.sv
module sim_csync_rx;
  localparam int CLK_P = 10;

  logic clk_i = 0, rst_ni = 0;
  logic bit_en_i = 0, rxd_i = 1, hunt_cmd_i = 0, ext_sync_en_i = 0, ext_sync_i = 0;
  logic two_syn_i = 0, syn_strip_i = 0, transp_i = 0, par_force_i = 0;
  logic [3:0] char_len_i = 4'd8;
  logic [1:0] par_mode_i = 2'd0;
  logic [7:0] syn_char_i = 8'h16, dle_char_i = 8'h10;
  logic       sync_o, data_valid_o, par_err_o;
  logic [7:0] data_o;

  int total = 0, bad = 0, gap = 0;
  bit done = 0;
  string cur_req = "R1";
  int got_d[$], got_p[$];

  always #(CLK_P/2) clk_i = ~clk_i;

  csync_rx u0 (.*);

  function automatic void chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
    end
  endfunction

  function automatic int nlen();
    if (char_len_i < 5) return 5;
    if (char_len_i > 8) return 8;
    return int'(char_len_i);
  endfunction

  function automatic int pbit_of(int d);
    int ones = 0;
    for (int i = 0; i < nlen(); i++) ones += (d >> i) & 1;
    case (par_mode_i)
      2'd1: return (ones % 2 == 0) ? 1 : 0;
      2'd2: return ones % 2;
      2'd3: return int'(par_force_i);
      default: return 0;
    endcase
  endfunction

  // reference model
  bit hq[$], fq[$];
  int e_sync = 0, e_valid = 0, e_data = 0, e_perr = 0, pend = 0;

  function automatic bit pat_ok(int need, int w, int n);
    int sm = syn_char_i & ((1 << n) - 1);
    for (int k = 0; k < need; k++) begin
      int idx = k % w;
      int ex = (idx < n) ? ((sm >> idx) & 1) : pbit_of(sm);
      if (int'(hq[hq.size() - need + k]) != ex) return 0;
    end
    return 1;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_sync = 0; e_valid = 0; e_data = 0; e_perr = 0; pend = 0;
      hq.delete(); fq.delete();
    end else begin
      int n, w, need, d, perr, msk;
      bit keep;
      n = nlen();
      w = n + ((par_mode_i != 0) ? 1 : 0);
      msk = (1 << n) - 1;
      e_valid = 0; e_perr = 0;
      if (hunt_cmd_i) begin
        e_sync = 0; pend = 0; hq.delete(); fq.delete();
      end else if (e_sync == 0) begin
        if (ext_sync_en_i && ext_sync_i) e_sync = 1;
        else if (bit_en_i) begin
          hq.push_back(rxd_i);
          if (hq.size() > 18) void'(hq.pop_front());
          need = two_syn_i ? 2 * w : w;
          if (hq.size() >= need && pat_ok(need, w, n)) e_sync = 1;
        end
      end else if (bit_en_i) begin
        fq.push_back(rxd_i);
        if (fq.size() == w) begin
          d = 0;
          for (int i = 0; i < n; i++) d |= int'(fq[i]) << i;
          perr = (par_mode_i != 0 && int'(fq[n]) != pbit_of(d)) ? 1 : 0;
          fq.delete();
          keep = 0;
          if (transp_i && pend) begin
            pend = 0; keep = (d != (syn_char_i & msk));
          end else if (transp_i && d == (dle_char_i & msk)) pend = 1;
          else keep = !(syn_strip_i && d == (syn_char_i & msk));
          if (keep) begin e_valid = 1; e_data = d; e_perr = perr; end
        end
      end
    end
  end

  always @(negedge clk_i) begin
    chk(cur_req, int'(sync_o), e_sync, "sync_o");
    chk(cur_req, int'(data_valid_o), e_valid, "data_valid_o");
    chk(cur_req, int'(par_err_o), e_perr, "par_err_o");
    chk(cur_req, int'(data_o), e_data, "data_o");
    if (data_valid_o) begin got_d.push_back(int'(data_o)); got_p.push_back(int'(par_err_o)); end
  end

  task automatic send_bit(int b);
    @(negedge clk_i); rxd_i = b[0]; bit_en_i = 1;
    @(negedge clk_i); bit_en_i = 0; rxd_i = ~b[0];
    repeat (gap) begin @(negedge clk_i); rxd_i = ~rxd_i; end  // R10 noise off-strobe
  endtask

  task automatic send_char(int c, int flip = 0);
    for (int i = 0; i < nlen(); i++) send_bit((c >> i) & 1);
    if (par_mode_i != 0) send_bit(pbit_of(c) ^ flip);
  endtask

  task automatic hunt();
    @(negedge clk_i); hunt_cmd_i = 1;
    @(negedge clk_i); hunt_cmd_i = 0;
    chk("R9", int'(sync_o), 0, "sync after hunt");
    got_d.delete(); got_p.delete();
  endtask

  task automatic settle();
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1", int'(sync_o), 0, "reset sync");
    chk("R1", int'(data_valid_o), 0, "reset valid");
    chk("R1", int'(data_o), 0, "reset data");
    chk("R1", int'(par_err_o), 0, "reset perr");
    rst_ni = 1;

    // R2 R5: single SYN, 8 bits, no parity, SYN passed through
    cur_req = "R2";
    send_bit(1); send_bit(0); send_bit(1);
    send_char('h16);
    settle();
    chk("R2", int'(sync_o), 1, "sync after SYN");
    cur_req = "R5";
    send_char('h41); send_char('h16); send_char('h42);
    settle();
    chk("R5", got_d.size(), 3, "count");
    chk("R5", got_d[0], 'h41, "c0"); chk("R5", got_d[1], 'h16, "c1"); chk("R5", got_d[2], 'h42, "c2");

    // R7 R9: strip SYN
    cur_req = "R7";
    hunt(); syn_strip_i = 1;
    send_char('h16); send_char('h16); send_char('h55); send_char('h16); send_char('h33);
    settle();
    chk("R7", got_d.size(), 2, "count");
    chk("R7", got_d[0], 'h55, "c0"); chk("R7", got_d[1], 'h33, "c1");
    syn_strip_i = 0;

    // R3 R6: two SYN, 7 bits, even parity
    cur_req = "R3";
    hunt(); two_syn_i = 1; char_len_i = 4'd7; par_mode_i = 2'd2;
    send_char('h16); send_char('h00);
    settle();
    chk("R3", int'(sync_o), 0, "one SYN only");
    send_char('h16); send_char('h16);
    settle();
    chk("R3", int'(sync_o), 1, "two SYN");
    cur_req = "R6";
    send_char('h2A); send_char('h15, 1);
    settle();
    chk("R6", got_d.size(), 2, "count");
    chk("R6", got_d[0], 'h2A, "c0"); chk("R6", got_p[0], 0, "p0");
    chk("R6", got_d[1], 'h15, "c1"); chk("R6", got_p[1], 1, "p1 even err");
    two_syn_i = 0;

    // R6 R10: len clamp 3->5, odd parity, gaps with noise
    cur_req = "R10";
    hunt(); char_len_i = 4'd3; par_mode_i = 2'd1; gap = 2;
    send_char('h16); send_char('h0A); send_char('h1F, 1); send_char('h03);
    settle();
    chk("R10", got_d.size(), 3, "count");
    chk("R5", got_d[0], 'h0A, "c0 len5"); chk("R6", got_p[1], 1, "odd err");
    chk("R10", got_d[2], 'h03, "c2"); chk("R6", got_p[2], 0, "p2");
    gap = 0;

    // R6 forced parity, len 6
    cur_req = "R6";
    hunt(); char_len_i = 4'd6; par_mode_i = 2'd3; par_force_i = 1;
    send_char('h16); send_char('h3F); send_char('h01, 1);
    settle();
    chk("R6", got_d.size(), 2, "count");
    chk("R6", got_p[0], 0, "forced ok"); chk("R6", got_p[1], 1, "forced err");
    chk("R6", got_d[1], 'h01, "c1");
    par_force_i = 0;

    // R4 external sync
    cur_req = "R4";
    hunt(); char_len_i = 4'd8; par_mode_i = 2'd0; ext_sync_en_i = 1;
    send_bit(1); send_bit(1); send_bit(0);
    @(negedge clk_i); ext_sync_i = 1;
    @(negedge clk_i); ext_sync_i = 0;
    chk("R4", int'(sync_o), 1, "ext sync");
    send_char('hA5);
    settle();
    chk("R4", got_d.size(), 1, "count");
    chk("R4", got_d[0], 'hA5, "c0");
    ext_sync_en_i = 0;

    // R8 transparent DLE handling
    cur_req = "R8";
    hunt(); transp_i = 1;
    send_char('h16);
    send_char('h10); send_char('h10); send_char('h41);
    send_char('h10); send_char('h16); send_char('h16);
    send_char('h10); send_char('h42);
    settle();
    chk("R8", got_d.size(), 4, "count");
    chk("R8", got_d[0], 'h10, "DLE DLE"); chk("R8", got_d[1], 'h41, "c1");
    chk("R8", got_d[2], 'h16, "plain SYN"); chk("R8", got_d[3], 'h42, "DLE x");

    // R9 hunt mid character drops partial frame and pending DLE
    cur_req = "R9";
    send_char('h10);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1);
    hunt();
    send_char('h16); send_char('h77);
    settle();
    chk("R9", got_d.size(), 1, "count");
    chk("R9", got_d[0], 'h77, "c0");
    transp_i = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL %s watchdog act=hung exp=finished", cur_req);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule